// File: doc/BRIEF.md
# Multi-Read-Port Local Memory

This block is a small data memory placed inside an accelerator that issues several loads in one operation. It presents `NUM_RD` logical read ports, one per parallel load, on top of storage banks that each have only one or two physical read ports and one write port. A request latches all read addresses at once. Once every port has its word, the block returns all of them together, marked by a one-cycle valid pulse.

A parameter picks how the gap between logical and physical ports is closed. With replication on, enough identical copies of the array are built for every logical port to get its own physical port. Every write goes to all copies in the same cycle, so one pass serves the whole request. With replication off, a single bank serves the requests over several passes, `PHYS_PORTS` ports per pass, in ascending port order. Intermediate results are staged until the last pass completes.

Top module: `mrp_local_mem`

## Requirements
- R1: After reset `rd_valid` and `busy` are 0 and every word of `rd_data` is 0.
- R2: For a served request, word i of `rd_data` (bits i*DATA_W upward) equals the memory content at logical read address i (`rd_addr` bits i*ADDR_W upward), for every i below NUM_RD.
- R3: With replication on, ceil(NUM_RD/PHYS_PORTS) banks are built and a request sampled at edge E0 completes with `rd_valid` high for exactly one cycle, the cycle after edge E1.
- R4: With replication off, a request takes ceil(NUM_RD/PHYS_PORTS) passes. Logical port i is read at edge E(1+floor(i/PHYS_PORTS)), and `rd_valid` is high for one cycle after the edge of the last pass.
- R5: A read is read-first: a write sampled at the same edge as the pass that reads its address returns the old word, and a write sampled at an earlier edge returns the new word.
- R6: A write (`wr_en`=1 at an edge) updates every replica, so all logical ports reading that address afterwards return the written word.
- R7: A `rd_req` sampled while `busy` is 1 is ignored: it produces no further `rd_valid` pulse and does not alter the results of the request in flight.
- R8: `rd_data` changes only at the edge that raises `rd_valid` and otherwise holds the last released results.
- R9: `busy` is 1 from the edge that accepts a request until the edge that raises `rd_valid`, and 0 in the valid cycle, where a new request may be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, broadcast to all banks |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_req | input | 1 | Read request, accepted when idle |
| rd_addr | input | NUM_RD*ADDR_W | Packed logical read addresses |
| rd_data | output | NUM_RD*DATA_W | Packed read results |
| rd_valid | output | 1 | One-cycle pulse when all results are released |
| busy | output | 1 | A request is being served |

## Verification
The hardest case is a write that lands exactly on a pass edge while a sequenced request is still in flight. There, ports read in the first pass must see the old word and ports read later must see the new one. The stimulus points every logical port at one address and drives a write to that address in the cycle after the request. It runs a replicated instance and a sequenced instance side by side, so the same stimulus must give all-old results on one instance and a split by port index on the other. A second request, placed in the cycle right after acceptance, checks that a busy instance drops it.

// File: rtl/mrp_pkg.sv
package mrp_pkg;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // banks built: one per group of physical ports when replicating, else one
  function automatic int bank_count(input int n_rd, input int n_phys, input bit replicate);
    return replicate ? ceil_div(n_rd, n_phys) : 1;
  endfunction

  // passes needed to serve every logical port over all physical lanes
  function automatic int pass_count(input int n_rd, input int n_phys, input bit replicate);
    return ceil_div(n_rd, bank_count(n_rd, n_phys, replicate) * n_phys);
  endfunction

  function automatic int width_of(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/mrp_bank.sv
module mrp_bank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int PORTS  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [PORTS*ADDR_W-1:0]  raddr,
  output logic [PORTS*DATA_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // asynchronous read ports; sampled downstream at the same edge as a write -> old data
  for (genvar q = 0; q < PORTS; q++) begin : g_rd
    assign rdata[q*DATA_W +: DATA_W] = mem[raddr[q*ADDR_W +: ADDR_W]];
  end

  // R6: every write lands in this copy
  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/mrp_sequencer.sv
module mrp_sequencer #(
  parameter int NPASS = 1,
  parameter int PW    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  output logic          busy,
  output logic [PW-1:0] pass_idx,
  output logic          accept,
  output logic          last,
  output logic          done
);
  logic          busy_q;
  logic [PW-1:0] pass_q;
  logic          done_q;

  assign accept   = req && !busy_q;
  assign last     = busy_q && (pass_q == PW'(NPASS - 1));
  assign busy     = busy_q;
  assign pass_idx = pass_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pass_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req) begin
          busy_q <= 1'b1;
          pass_q <= '0;
        end
      end else if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        pass_q <= pass_q + 1'b1;
      end
    end
  end

  // checker: busy cycles since acceptance
  logic [15:0] chk_busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chk_busy_cnt <= '0;
    else if (accept)  chk_busy_cnt <= '0;
    else if (busy_q)  chk_busy_cnt <= chk_busy_cnt + 1'b1;
  end

  assert_pass_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> chk_busy_cnt == 16'(NPASS));

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_busy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

endmodule

// File: rtl/mrp_collect.sv
module mrp_collect #(
  parameter int NUM_RD = 8,
  parameter int LANES  = 8,
  parameter int NPASS  = 1,
  parameter int PW     = 1,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     serve,
  input  logic [PW-1:0]            pass_idx,
  input  logic                     last,
  input  logic [LANES*DATA_W-1:0]  lane_data,
  output logic [NUM_RD*DATA_W-1:0] rd_data
);
  for (genvar i = 0; i < NUM_RD; i++) begin : g_port
    localparam int PI = i / LANES;
    localparam int LI = i % LANES;
    if (PI == NPASS - 1) begin : g_direct
      // served in the final pass: straight into the output register
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rd_data[i*DATA_W +: DATA_W] <= '0;
        else if (last) rd_data[i*DATA_W +: DATA_W] <= lane_data[LI*DATA_W +: DATA_W];
      end
    end else begin : g_staged
      logic [DATA_W-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= '0;
          rd_data[i*DATA_W +: DATA_W] <= '0;
        end else begin
          if (serve && pass_idx == PW'(PI)) stage_q <= lane_data[LI*DATA_W +: DATA_W];
          if (last) rd_data[i*DATA_W +: DATA_W] <= stage_q;
        end
      end
    end
  end

  assert_pass_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    serve |-> 32'(pass_idx) < NPASS);

endmodule

// File: rtl/mrp_local_mem.sv
module mrp_local_mem #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 5,
  parameter int NUM_RD     = 8,
  parameter int PHYS_PORTS = 2,
  parameter bit REPLICATE  = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_req,
  input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
  output logic [NUM_RD*DATA_W-1:0] rd_data,
  output logic                     rd_valid,
  output logic                     busy
);
  localparam int NB    = mrp_pkg::bank_count(NUM_RD, PHYS_PORTS, REPLICATE);
  localparam int LANES = NB * PHYS_PORTS;
  localparam int NPASS = mrp_pkg::pass_count(NUM_RD, PHYS_PORTS, REPLICATE);
  localparam int SLOTS = NPASS * LANES;
  localparam int PW    = mrp_pkg::width_of(NPASS);

  logic          accept;
  logic          last;
  logic          seq_busy;
  logic          seq_done;
  logic [PW-1:0] pass_idx;

  mrp_sequencer #(.NPASS(NPASS), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .busy(seq_busy),
    .pass_idx(pass_idx), .accept(accept), .last(last), .done(seq_done)
  );

  assign busy     = seq_busy;
  assign rd_valid = seq_done;

  // latched addresses; slots past NUM_RD are padding that read address 0
  logic [ADDR_W-1:0] addr_q [SLOTS];
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NUM_RD) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      addr_q[i] <= '0;
        else if (accept) addr_q[i] <= rd_addr[i*ADDR_W +: ADDR_W];
      end
    end else begin : g_pad
      assign addr_q[i] = '0;
    end
  end

  // lane address steering: lane l in pass p serves logical port p*LANES+l
  logic [ADDR_W-1:0] lane_addr [LANES];
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l] = '0;
      for (int p = 0; p < NPASS; p++) begin
        if (pass_idx == PW'(p)) lane_addr[l] = addr_q[p*LANES + l];
      end
    end
  end

  logic [LANES*DATA_W-1:0] lane_data;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [PHYS_PORTS*ADDR_W-1:0] bank_raddr;
    for (genvar q = 0; q < PHYS_PORTS; q++) begin : g_lane
      assign bank_raddr[q*ADDR_W +: ADDR_W] = lane_addr[b*PHYS_PORTS + q];
    end
    mrp_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PORTS(PHYS_PORTS)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
      .raddr(bank_raddr),
      .rdata(lane_data[b*PHYS_PORTS*DATA_W +: PHYS_PORTS*DATA_W])
    );
  end

  mrp_collect #(.NUM_RD(NUM_RD), .LANES(LANES), .NPASS(NPASS), .PW(PW), .DATA_W(DATA_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .serve(seq_busy), .pass_idx(pass_idx), .last(last),
    .lane_data(lane_data), .rd_data(rd_data)
  );

  // R8: results move only together with the valid pulse
  assert_data_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

  // R7: a request seen while busy starts nothing new
  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);

endmodule

// File: tb/mrp_local_mem_tb.sv
`timescale 1ns/1ps
module mrp_local_mem_tb_top;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int N  = 8;
  localparam int P  = 2;
  localparam int NP_REP  = 1;
  localparam int NP_SEQ  = (N + P - 1) / P;
  localparam int L_REP   = N;
  localparam int L_SEQ   = P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic rd_req = 1'b0;
  logic [N*AW-1:0] rd_addr = '0;
  logic [N*DW-1:0] data_rep, data_seq;
  logic valid_rep, valid_seq, busy_rep, busy_seq;

  always #2 clk = ~clk;

  mrp_local_mem #(.DATA_W(DW), .ADDR_W(AW), .NUM_RD(N), .PHYS_PORTS(P), .REPLICATE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(data_rep), .rd_valid(valid_rep), .busy(busy_rep));

  mrp_local_mem #(.DATA_W(DW), .ADDR_W(AW), .NUM_RD(N), .PHYS_PORTS(P), .REPLICATE(1'b0)) dut_seq_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(data_seq), .rd_valid(valid_seq), .busy(busy_seq));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DW-1:0] model [1 << AW];

  logic [N*DW-1:0] q_rep[$], q_seq[$];
  int t_rep[$], t_seq[$];
  logic [N*DW-1:0] last_rep, last_seq;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected results when a valid pulse shows up
  task automatic observe(input bit seq, input logic [N*DW-1:0] act);
    logic [N*DW-1:0] exp;
    int t;
    if (seq ? (q_seq.size() == 0) : (q_rep.size() == 0)) begin
      check("R7 unexpected valid", 1, 0);
      return;
    end
    if (seq) begin exp = q_seq.pop_front(); t = t_seq.pop_front(); last_seq = exp; end
    else     begin exp = q_rep.pop_front(); t = t_rep.pop_front(); last_rep = exp; end
    check(seq ? "R4 latency" : "R3 latency", 64'(cyc), 64'(t));
    for (int i = 0; i < N; i++)
      check(seq ? "R2/R5 seq word" : "R2/R5 rep word", 64'(act[i*DW +: DW]), 64'(exp[i*DW +: DW]));
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_rep) observe(1'b0, data_rep);
    if (rst_n && valid_seq) observe(1'b1, data_seq);
  end

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  // driver: issue one request; optionally a write in the next cycle (lands on edge E1)
  // and optionally a second request in the next cycle (must be ignored)
  task automatic do_read(input logic [AW-1:0] a [N], input bit hit,
                         input logic [AW-1:0] wa, input logic [DW-1:0] wd, input bit extra);
    logic [N*DW-1:0] er, es;
    for (int i = 0; i < N; i++) begin
      er[i*DW +: DW] = (hit && (i / L_REP) >= 1 && a[i] == wa) ? wd : model[a[i]];
      es[i*DW +: DW] = (hit && (i / L_SEQ) >= 1 && a[i] == wa) ? wd : model[a[i]];
      rd_addr[i*AW +: AW] = a[i];
    end
    q_rep.push_back(er); t_rep.push_back(cyc + 1 + NP_REP);
    q_seq.push_back(es); t_seq.push_back(cyc + 1 + NP_SEQ);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check("R9 busy after accept rep", 64'(busy_rep), 1);
    check("R9 busy after accept seq", 64'(busy_seq), 1);
    if (extra) begin
      rd_req = 1'b1;
      for (int i = 0; i < N; i++) rd_addr[i*AW +: AW] = AW'(31 - i);
    end
    if (hit) write_word(wa, wd);
    else @(negedge clk);
    rd_req = 1'b0;
    for (int k = 0; k < NP_SEQ + 2; k++) @(negedge clk);
  endtask

  initial begin
    logic [AW-1:0] a [N];
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid rep", 64'(valid_rep), 0);
    check("R1 valid seq", 64'(valid_seq), 0);
    check("R1 busy", 64'({busy_rep, busy_seq}), 0);
    check("R1 data rep", 64'(data_rep != '0), 0);
    check("R1 data seq", 64'(data_seq != '0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int x = 0; x < (1 << AW); x++) write_word(AW'(x), DW'(16'hA000 ^ (x * 37)));

    // R2/R3/R4: ascending distinct addresses
    for (int i = 0; i < N; i++) a[i] = AW'(i);
    do_read(a, 1'b0, '0, '0, 1'b0);
    // scattered addresses
    for (int i = 0; i < N; i++) a[i] = AW'((i * 13 + 7) % 32);
    do_read(a, 1'b0, '0, '0, 1'b0);
    // R6: write, then every port reads it
    write_word(5'd9, 16'h5A5A);
    for (int i = 0; i < N; i++) a[i] = 5'd9;
    do_read(a, 1'b0, '0, '0, 1'b0);
    // R5/R4: write lands on the first pass edge
    for (int i = 0; i < N; i++) a[i] = 5'd12;
    do_read(a, 1'b1, 5'd12, 16'hBEEF, 1'b0);
    // R7: second request in the cycle after acceptance is dropped
    for (int i = 0; i < N; i++) a[i] = AW'(20 + i % 4);
    do_read(a, 1'b0, '0, '0, 1'b1);

    // R8: results held after release
    repeat (5) @(negedge clk);
    check("R8 hold rep", 64'(data_rep == last_rep), 1);
    check("R8 hold seq", 64'(data_seq == last_seq), 1);
    check("R7 no pending rep", 64'(q_rep.size()), 0);
    check("R7 no pending seq", 64'(q_seq.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule